// File: doc/BRIEF.md
# Full-Duplex Control SPI Port with Receive Holding Register

This block is a byte-wide serial control port that can run as the clock-driving end of the link (master) or as the clocked end (slave). Every transfer is full duplex. While one character leaves on a data line, another arrives on the other line. There is one shift register. A write to the data register goes straight into that register, so the transmit side has no queue. Each finished character is copied into a separate holding register, so software can read it while the next character is already being shifted.

The two data pins change roles with the mode. Pin A drives in master mode and listens in slave mode. Pin B does the opposite. In master mode the serial clock comes from the system clock through a programmable divider, and both its idle level and its sampling phase can be selected. In slave mode the serial clock, the select line and pin A are brought into the clock domain through synchronizers. The slave responds only while its active-low select is asserted. Software sees three byte-wide registers and a set of sticky status flags.

Top module: `spi_ctl_port`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) read zero, no output enable is active and the serial clock output is low.
- R2: A master transfer, started by writing address 2 while idle, sends that byte MSB first on pin A and assembles the byte arriving on pin B MSB first. Reading address 2 afterwards returns the received byte.
- R3: Control bits [7:4] hold a divider code D. The master clock toggles every D+1 system clocks, so 8 bits take 16*(D+1) cycles. The transfer-complete flag (status bit 0) reads set exactly 16*(D+1) clock edges after the edge that accepted the write. While idle the clock rests at the level of control bit 2 (polarity).
- R4: Control bit 3 selects the phase. With phase 0 the incoming bit is sampled on the leading clock edge and the outgoing bit changes on the trailing edge. With phase 1 the outgoing bit changes on the leading edge and sampling happens on the trailing edge. Every transfer has exactly 8 leading and 8 trailing edges.
- R5: Control bit 0 enables the port and control bit 1 selects master mode. In master mode pin A and the clock are driven and pin B is not. In slave mode pin A and the clock are never driven, and pin B is driven only while the slave is selected.
- R6: While its select input is high, a slave ignores the serial clock. Its bit count restarts, so a transfer that was broken off by deselection leaves no partial byte behind.
- R7: Status bit 0 is set when a byte lands in the holding register and is cleared by reading address 2. The holding register can be read while the next byte is being shifted, and that next byte then completes without error.
- R8: If a byte completes while status bit 0 is still set, overrun (status bit 1) is set and the holding register keeps the older byte.
- R9: A write to address 2 while a transfer is in progress (master busy, or slave selected) sets the write-collision flag (status bit 2). The byte being shifted out does not change.
- R10: Reading address 1 clears the overrun and write-collision flags. Status bit 3 reports busy.
- R11: In slave mode, with either phase and either polarity, the port returns its preloaded byte on pin B and receives the byte presented on pin A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational on reg_addr |
| sck_in | input | 1 | Serial clock from a remote master |
| sck_out | output | 1 | Serial clock generated in master mode |
| sck_oe | output | 1 | Drive enable for the serial clock |
| ss_n | input | 1 | Active-low slave select |
| da_in | input | 1 | Pin A input value (slave receive data) |
| da_out | output | 1 | Pin A output value (master transmit data) |
| da_oe | output | 1 | Pin A drive enable |
| db_in | input | 1 | Pin B input value (master receive data) |
| db_out | output | 1 | Pin B output value (slave transmit data) |
| db_oe | output | 1 | Pin B drive enable |

## Verification
The bench sweeps all four polarity and phase combinations against a remote-end model that presents and captures bits on the proper edges. A design with the phases swapped would receive a byte shifted by one bit. The completion cycle is probed one edge early and exactly on time, which catches a divider that is off by one. Back-to-back transfers without a read must keep the first byte; a design that let the overwrite through would return the second byte. A write in the middle of a transfer must leave the byte on the wire intact. Stray clocks while deselected, and a transfer cut off after three bits, must not shift the bit count; a slave that kept counting would put the next byte out of alignment.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2
  } reg_addr_e;

  // control register: {div[3:0], cpha, cpol, master, en}
  typedef struct packed {
    logic [3:0] div;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       en;
  } ctrl_t;

  // system clocks per serial half period for a divider code
  function automatic int unsigned half_period(input logic [3:0] div);
    return int'(div) + 1;
  endfunction

  // the divider counter has reached its terminal count
  function automatic logic tick_due(input logic [3:0] hcnt, input logic [3:0] div);
    return hcnt == div;
  endfunction

  // status register packing: {busy, wcol, ovr, done}
  function automatic logic [3:0] pack_stat(input logic done, input logic ovr,
                                           input logic wcol, input logic busy);
    return {busy, wcol, ovr, done};
  endfunction

endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_ctl_clkgen.sv
module spi_ctl_clkgen import spi_ctl_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [3:0] div,
  output logic       ph,
  output logic       lead_p,
  output logic       trail_p
);
  logic [3:0] hcnt;
  logic       tick;

  assign tick    = active && tick_due(hcnt, div);
  assign lead_p  = tick && !ph;
  assign trail_p = tick && ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      ph   <= 1'b0;
    end else if (!active) begin
      hcnt <= '0;
      ph   <= 1'b0;
    end else if (tick) begin
      hcnt <= '0;
      ph   <= ~ph;
    end else begin
      hcnt <= hcnt + 4'd1;
    end
  end
endmodule

// File: rtl/spi_ctl_shifter.sv
module spi_ctl_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          lead,
  input  logic          trail,
  input  logic          cpha,
  input  logic          in_bit,
  input  logic          resync,
  input  logic          clr,
  output logic          dout,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte,
  output logic [DW-1:0] shreg
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt;
  logic          lat;

  assign rx_byte   = {shreg[DW-2:0], cpha ? in_bit : lat};
  assign byte_done = trail && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      lat   <= 1'b0;
      dout  <= 1'b0;
    end else if (load) begin
      shreg <= load_data;
      cnt   <= '0;
      dout  <= load_data[DW-1];
    end else if (clr) begin
      cnt <= '0;
    end else begin
      if (resync) dout <= shreg[DW-1];
      if (lead) begin
        if (cpha) dout <= shreg[DW-1];
        else      lat  <= in_bit;
      end
      if (trail) begin
        shreg <= rx_byte;
        if (!cpha) dout <= shreg[DW-2];
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs import spi_ctl_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          wcol_set,
  input  logic          busy,
  output ctrl_t         ctrl,
  output logic          done,
  output logic          ovr,
  output logic          wcol,
  output logic [DW-1:0] rbuf,
  output logic          rd_data,
  output logic          rd_stat
);
  logic wr_ctrl;

  assign wr_ctrl = wr && (addr == A_CTRL);
  assign rd_data = rd && (addr == A_DATA);
  assign rd_stat = rd && (addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (wr_ctrl) ctrl <= ctrl_t'(wdata[7:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      ovr  <= 1'b0;
      wcol <= 1'b0;
      rbuf <= '0;
    end else begin
      if (byte_done && done && !rd_data) begin
        ovr <= 1'b1;
      end else begin
        if (byte_done) begin
          rbuf <= rx_byte;
          done <= 1'b1;
        end else if (rd_data) begin
          done <= 1'b0;
        end
        if (rd_stat) ovr <= 1'b0;
      end
      if (wcol_set)     wcol <= 1'b1;
      else if (rd_stat) wcol <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = DW'(ctrl);
      A_STAT:  rdata = DW'(pack_stat(done, ovr, wcol, busy));
      A_DATA:  rdata = rbuf;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port import spi_ctl_pkg::*; #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sck_in,
  output logic          sck_out,
  output logic          sck_oe,
  input  logic          ss_n,
  input  logic          da_in,
  output logic          da_out,
  output logic          da_oe,
  input  logic          db_in,
  output logic          db_out,
  output logic          db_oe
);
  ctrl_t         ctrl;
  logic          master_mode, slave_mode;
  logic          sck_s, ss_s, da_s, sck_d, sel, sel_d;
  logic          mbusy, busy, wr_data, load, wcol_set;
  logic          m_ph, m_lead, m_trail, s_lead, s_trail, s_edge;
  logic          lead, trail, in_bit, dout;
  logic          byte_done, done, ovr, wcol, rd_data, rd_stat;
  logic [DW-1:0] rx_byte, rbuf, shreg;

  assign master_mode = ctrl.en && ctrl.master;
  assign slave_mode  = ctrl.en && !ctrl.master;

  spi_ctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_in, ss_n, da_in}),
    .q({sck_s, ss_s, da_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      sel_d <= 1'b0;
    end else begin
      sck_d <= sck_s;
      sel_d <= sel;
    end
  end

  assign sel     = slave_mode && !ss_s;
  assign s_edge  = sel && (sck_s != sck_d);
  assign s_lead  = s_edge && (sck_s != ctrl.cpol);
  assign s_trail = s_edge && (sck_s == ctrl.cpol);

  assign busy     = master_mode ? mbusy : sel;
  assign wr_data  = reg_wr && (reg_addr == A_DATA);
  assign load     = wr_data && !busy;
  assign wcol_set = wr_data && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        mbusy <= 1'b0;
    else if (load && master_mode)      mbusy <= 1'b1;
    else if (byte_done || !master_mode) mbusy <= 1'b0;
  end

  spi_ctl_clkgen u_clkgen (
    .clk(clk), .rst_n(rst_n),
    .active(mbusy && master_mode), .div(ctrl.div),
    .ph(m_ph), .lead_p(m_lead), .trail_p(m_trail)
  );

  assign lead   = master_mode ? m_lead  : s_lead;
  assign trail  = master_mode ? m_trail : s_trail;
  assign in_bit = master_mode ? db_in   : da_s;

  spi_ctl_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_data(reg_wdata),
    .lead(lead), .trail(trail), .cpha(ctrl.cpha), .in_bit(in_bit),
    .resync(sel && !sel_d), .clr(slave_mode && !sel),
    .dout(dout), .byte_done(byte_done), .rx_byte(rx_byte), .shreg(shreg)
  );

  spi_ctl_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .byte_done(byte_done), .rx_byte(rx_byte), .wcol_set(wcol_set), .busy(busy),
    .ctrl(ctrl), .done(done), .ovr(ovr), .wcol(wcol), .rbuf(rbuf),
    .rd_data(rd_data), .rd_stat(rd_stat)
  );

  assign sck_out = ctrl.cpol ^ m_ph;
  assign sck_oe  = master_mode;
  assign da_out  = dout;
  assign da_oe   = master_mode;
  assign db_out  = dout;
  assign db_oe   = sel;
endmodule

// File: rtl/spi_ctl_port_chk.sv
module spi_ctl_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          da_oe,
  input logic          db_oe,
  input logic          sck_oe,
  input logic          sck_out,
  input logic          cpol,
  input logic          busy,
  input logic          byte_done,
  input logic          done,
  input logic          ovr,
  input logic          wcol,
  input logic [DW-1:0] rbuf,
  input logic [DW-1:0] rx_byte,
  input logic [DW-1:0] shreg,
  input logic          rd_data,
  input logic          rd_stat,
  input logic          wr_data,
  input logic          sel,
  input logic          slave_mode
);
  p_pin_roles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(da_oe && db_oe) && !(sck_oe && db_oe));

  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && !busy) |-> (sck_out == cpol));

  p_done_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !done) |=> (done && rbuf == $past(rx_byte)));

  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !byte_done) |=> !done);

  p_overrun_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && done && !rd_data) |=> (ovr && $stable(rbuf)));

  p_collision_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy && !byte_done) |=> (wcol && shreg == $past(shreg) || !$stable(shreg) && wcol));

  p_stat_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !wr_data && !byte_done) |=> (!wcol && !ovr));

  p_deselect_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && !sel) |-> !byte_done);
endmodule

bind spi_ctl_port spi_ctl_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .da_oe(da_oe), .db_oe(db_oe), .sck_oe(sck_oe), .sck_out(sck_out),
  .cpol(ctrl.cpol), .busy(busy), .byte_done(byte_done),
  .done(done), .ovr(ovr), .wcol(wcol), .rbuf(rbuf), .rx_byte(rx_byte),
  .shreg(shreg), .rd_data(rd_data), .rd_stat(rd_stat), .wr_data(wr_data),
  .sel(sel), .slave_mode(slave_mode)
);

// File: tb/spi_ctl_port_test.sv
module spi_ctl_port_test;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          sck_in = 1'b0, ss_n = 1'b1, da_in = 1'b0;
  logic          sck_out, sck_oe, da_out, da_oe, db_in, db_out, db_oe;

  always #2 clk = ~clk;

  spi_ctl_port #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_in(sck_in), .sck_out(sck_out),
    .sck_oe(sck_oe), .ss_n(ss_n), .da_in(da_in), .da_out(da_out), .da_oe(da_oe),
    .db_in(db_in), .db_out(db_out), .db_oe(db_oe)
  );

  int  n_run = 0, n_fail = 0;
  bit  ended = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrl_byte(input bit en, input bit mst, input bit cpol,
                                           input bit cpha, input int div);
    return {4'(div), cpha, cpol, mst, en};
  endfunction

  function automatic int cycles_to_done(input int div);
    return 16 * (div + 1);
  endfunction

  // all register tasks start and end on a falling clock edge
  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // remote slave model for master-mode runs
  bit            m_on = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0;
  logic [DW-1:0] s_byte = '0, cap = '0;
  int            lead_n = 0, trail_n = 0;

  always @(sck_out) begin
    if (m_on) begin
      if (sck_out != m_cpol) begin
        lead_n++;
        if (!m_cpha) cap = {cap[DW-2:0], da_out};
      end else begin
        trail_n++;
        if (m_cpha) cap = {cap[DW-2:0], da_out};
      end
    end
  end

  always @* begin
    int idx;
    idx = m_cpha ? lead_n - 1 : trail_n;
    db_in = (m_on && idx >= 0 && idx < DW) ? s_byte[DW-1-idx] : 1'b0;
  end

  task automatic m_start(input bit cpol, input bit cpha, input int div,
                         input logic [7:0] tx, input logic [7:0] stx);
    m_on = 1'b0;
    wr_reg(2'd0, ctrl_byte(1, 1, cpol, cpha, div));
    m_cpol = cpol; m_cpha = cpha; lead_n = 0; trail_n = 0; cap = '0;
    s_byte = stx; m_on = 1'b1;
    wr_reg(2'd2, tx);
  endtask

  // slave-mode driver: the bench plays the remote master, 6 clocks per half period
  task automatic s_bits(input int n, input bit cpol, input bit cpha,
                        input logic [7:0] mtx, inout logic [7:0] got);
    for (int i = 0; i < n; i++) begin
      if (!cpha) begin
        da_in = mtx[DW-1-i];
        idle(6);
        got = {got[DW-2:0], db_out};
        sck_in = ~cpol; idle(6); sck_in = cpol;
      end else begin
        sck_in = ~cpol; da_in = mtx[DW-1-i];
        idle(6);
        got = {got[DW-2:0], db_out};
        sck_in = cpol; idle(6);
      end
      chk(db_oe && !da_oe && !sck_oe, "R5 slave pin roles while selected",
          {db_oe, da_oe, sck_oe}, 3'b100);
    end
    idle(6);
  endtask

  task automatic s_xfer(input bit cpol, input bit cpha, input logic [7:0] stx,
                        input logic [7:0] mtx);
    logic [7:0] got, d;
    got = '0;
    sck_in = cpol;
    wr_reg(2'd0, ctrl_byte(1, 0, cpol, cpha, 0));
    idle(6);
    wr_reg(2'd2, stx);
    ss_n = 1'b0; idle(6);
    s_bits(8, cpol, cpha, mtx, got);
    ss_n = 1'b1; idle(6);
    chk(!db_oe, "R5 slave pin B released after deselect", db_oe, 0);
    peek(2'd1, d);
    chk(d[0] == 1'b1, "R11 slave done flag", d, 1);
    rd_reg(2'd2, d);
    chk(d == mtx, "R11 slave receive byte", d, mtx);
    chk(got == stx, "R11 slave transmit byte", got, stx);
  endtask

  initial begin
    logic [7:0] d, tx, stx;
    int dv;
    bit cp, ch;
    void'($urandom(32'h5EED_2024));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    peek(2'd1, d); chk(d == 8'h00, "R1 status after reset", d, 0);
    peek(2'd0, d); chk(d == 8'h00, "R1 control after reset", d, 0);
    chk({da_oe, db_oe, sck_oe, sck_out} == 4'b0, "R1 outputs after reset",
        {da_oe, db_oe, sck_oe, sck_out}, 0);

    // R3 exact completion cycle, R2 data, R5 master pins, R7 clear on read
    m_start(0, 0, 2, 8'hA5, 8'h3C);
    chk(da_oe && sck_oe && !db_oe, "R5 master pin roles", {da_oe, sck_oe, db_oe}, 3'b110);
    peek(2'd1, d); chk(d[3] == 1'b1, "R10 busy bit during transfer", d[3], 1);
    idle(cycles_to_done(2) - 1);
    peek(2'd1, d); chk(d[0] == 1'b0, "R3 done not yet one edge early", d[0], 0);
    idle(1);
    peek(2'd1, d); chk(d[0] == 1'b1, "R3 done on exact edge", d[0], 1);
    chk(sck_out == 1'b0, "R3 idle clock level polarity 0", sck_out, 0);
    chk(cap == 8'hA5, "R2 transmitted byte on pin A", cap, 8'hA5);
    rd_reg(2'd2, d); chk(d == 8'h3C, "R2 received byte from pin B", d, 8'h3C);
    peek(2'd1, d); chk(d[0] == 1'b0, "R7 done cleared by data read", d[0], 0);

    // R2 R4 random master sweep over polarity, phase and divider
    for (int k = 0; k < 24; k++) begin
      cp = 1'($urandom_range(1, 0)); ch = 1'($urandom_range(1, 0));
      dv = $urandom_range(3, 0);
      tx = 8'($urandom); stx = 8'($urandom);
      m_start(cp, ch, dv, tx, stx);
      idle(cycles_to_done(dv) + 2);
      rd_reg(2'd2, d);
      chk(d == stx, "R4 master receive under random mode", d, stx);
      chk(cap == tx, "R4 master transmit under random mode", cap, tx);
      chk(lead_n == 8 && trail_n == 8, "R4 eight edge pairs", lead_n * 16 + trail_n, 8 * 16 + 8);
      chk(sck_out == cp, "R3 clock rests at polarity", sck_out, cp);
    end

    // R8 overrun keeps the older byte, R10 status read clears it
    m_start(1, 0, 0, 8'h01, 8'h11); idle(cycles_to_done(0) + 2);
    m_start(1, 0, 0, 8'h02, 8'h22); idle(cycles_to_done(0) + 2);
    rd_reg(2'd1, d);
    chk(d[1:0] == 2'b11, "R8 overrun and done both set", d[1:0], 3);
    peek(2'd1, d); chk(d[1] == 1'b0, "R10 overrun cleared by status read", d[1], 0);
    rd_reg(2'd2, d); chk(d == 8'h11, "R8 holding register kept old byte", d, 8'h11);

    // R7 read holding register while the next byte shifts
    m_start(0, 1, 1, 8'h0F, 8'h44); idle(cycles_to_done(1) + 2);
    m_start(0, 1, 1, 8'hF0, 8'h55); idle(8);
    rd_reg(2'd2, d); chk(d == 8'h44, "R7 read first byte during second", d, 8'h44);
    idle(cycles_to_done(1));
    peek(2'd1, d); chk(d[1:0] == 2'b01, "R7 second byte done without overrun", d[1:0], 1);
    rd_reg(2'd2, d); chk(d == 8'h55, "R7 second byte received", d, 8'h55);

    // R9 write collision leaves the outgoing byte intact
    m_start(0, 1, 3, 8'h5A, 8'h96); idle(10);
    wr_reg(2'd2, 8'hFF);
    idle(cycles_to_done(3));
    chk(cap == 8'h5A, "R9 outgoing byte unchanged after collision", cap, 8'h5A);
    rd_reg(2'd1, d); chk(d[2] == 1'b1, "R9 collision flag set", d[2], 1);
    peek(2'd1, d); chk(d[2] == 1'b0, "R10 collision cleared by status read", d[2], 0);
    rd_reg(2'd2, d); chk(d == 8'h96, "R9 receive unaffected by collision", d, 8'h96);
    m_on = 1'b0;

    // R11 slave transfers, directed then random
    s_xfer(0, 0, 8'hC3, 8'h5A);
    s_xfer(1, 1, 8'h81, 8'h7E);
    for (int k = 0; k < 6; k++) begin
      s_xfer(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), 8'($urandom), 8'($urandom));
    end

    // R6 clocks ignored while deselected, broken transfer leaves no residue
    sck_in = 1'b0;
    wr_reg(2'd0, ctrl_byte(1, 0, 0, 0, 0));
    wr_reg(2'd2, 8'hAA);
    for (int k = 0; k < 10; k++) begin
      sck_in = 1'b1; idle(6); sck_in = 1'b0; idle(6);
    end
    peek(2'd1, d); chk(d[0] == 1'b0, "R6 no completion while deselected", d[0], 0);
    chk(!db_oe, "R6 pin B quiet while deselected", db_oe, 0);
    begin
      logic [7:0] junk;
      junk = '0;
      ss_n = 1'b0; idle(6);
      s_bits(3, 0, 0, 8'hE0, junk);
      ss_n = 1'b1; idle(6);
    end
    peek(2'd1, d); chk(d[0] == 1'b0, "R6 partial transfer not completed", d[0], 0);
    begin
      logic [7:0] got;
      got = '0;
      wr_reg(2'd2, 8'h3C);
      ss_n = 1'b0; idle(6);
      s_bits(8, 0, 0, 8'h69, got);
      ss_n = 1'b1; idle(6);
      rd_reg(2'd2, d);
      chk(d == 8'h69, "R6 byte aligned after broken transfer", d, 8'h69);
      chk(got == 8'h3C, "R6 transmit aligned after broken transfer", got, 8'h3C);
    end

    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule